// File: doc/BRIEF.md
# Hierarchical Interrupt Request Controller

This block gathers interrupt flags from several on-chip peripheral groups and from a set of external request pins. It merges them into a single interrupt request line for a processor core. Flags from on-chip peripherals are already synchronous, so they reach the request line through combinational gating only. External pins are asynchronous and active low. Outside the low-power halt state, each pin passes a sampling glitch filter before it is used. A request must clear four gating stages in turn: its own flag enable, its group enable, a system enable and a global enable. While the core is servicing an interrupt, no new request is presented.

The filter samples on every cycle of the undivided source clock. The rest of the logic advances only on a system strobe `sys_en`, which marks one source cycle out of every N, where N is the clock divide ratio. A larger divide ratio therefore means fewer system cycles pass before an external request is recognized. Each external input can be set to edge mode or level mode. In the halt state the filter is bypassed, so an enabled pin that goes low raises a wake request at once.

Top module: `irq_hier_ctrl`

## Requirements
- R1: With every enable set and no interrupt in service, a set on-chip flag drives `irq_req` high in the same cycle, with no register in the path.
- R2: Outside the halt state, an external pin is seen only after it has held a new value for 3 consecutive source-clock samples. A low pulse lasting 2 source cycles never reaches `ext_flag`.
- R3: The filter runs on the source clock and ignores `sys_en`. With a divide ratio of 3, a level-mode pin that goes low right after a strobe raises `irq_req` after 3 source cycles, which is only one system strobe later.
- R4: A flag whose own bit in `int_local_en` or `ext_local_en` is 0 does not set its group's `grp_pend` bit and does not raise `irq_req`.
- R5: Group g (flags g*4 to g*4+3 for g = 0..2, with the external flags as group 3) shows in `grp_pend[g]` only while `grp_en[g]` is 1.
- R6: With `sys_ie` at 0, `irq_req` stays low even when a `grp_pend` bit is set.
- R7: With `glob_ie` at 0, `irq_req` stays low even when a `grp_pend` bit is set.
- R8: When `irq_ack` is high on a strobe cycle, `in_service` is set, and `irq_req` stays low while `in_service` is set. When `irq_reti` is high on a strobe cycle, `in_service` is cleared. `irq_ack` is ignored on cycles without a strobe.
- R9: In edge mode (`ext_edge_sel` bit = 1), a filtered falling edge sets the flag on the next strobe. The flag stays set after the pin returns high and is cleared by a strobe-cycle pulse on its `ext_clr` bit.
- R10: In level mode (`ext_edge_sel` bit = 0), the flag is the inverse of the filtered pin. It rises 3 source cycles after the pin goes low and falls 3 source cycles after the pin goes high.
- R11: While `stop_mode` is 1, a low external pin with its local enable set drives `wake_req` high combinationally. `wake_req` is 0 whenever `stop_mode` is 0.
- R12: After reset, `irq_req`, `in_service`, `ext_flag`, `grp_pend` and `wake_req` are all 0, with the pins idle high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Undivided source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sys_en | input | 1 | System strobe, high one source cycle in N |
| stop_mode | input | 1 | Halt state: filter bypassed, wake path active |
| int_flag | input | 12 | On-chip peripheral flags, 3 groups of 4 |
| int_local_en | input | 12 | Per-flag enables for on-chip flags |
| ext_pin_n | input | 6 | External request pins, active low, asynchronous |
| ext_local_en | input | 6 | Per-flag enables for external flags |
| ext_edge_sel | input | 6 | 1 = edge mode, 0 = level mode |
| ext_clr | input | 6 | Clear pulses for edge-mode flags |
| grp_en | input | 4 | Group enables, bit 3 is the external group |
| sys_ie | input | 1 | System interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Core acknowledge pulse |
| irq_reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the core |
| in_service | output | 1 | Interrupt-in-service state |
| ext_flag | output | 6 | External flags after the filter and mode logic |
| grp_pend | output | 4 | Gated pending indication per group |
| wake_req | output | 1 | Wake request while in the halt state |

## Verification
Several properties are checked on every cycle: a filtered value can change only after the pin has held that value on the previous samples; `in_service` moves only on strobe cycles, following acknowledge and return; no request is presented while an interrupt is in service; an edge flag stays set until it is cleared; and `wake_req` appears only in the halt state. Other behaviour can only be shown by the bench's scenarios. These are the exact recognition latency at divide ratios 1 and 3, the rejection of a two-cycle glitch, each enable level blocking in turn, and the combinational wake path before any clock edge.

// File: rtl/irq_hier_pkg.sv
package irq_hier_pkg;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_EDGE  = 1'b1
   } trig_mode_e;

   function automatic logic all_same(input logic [31:0] v, input int unsigned n);
      logic ones;
      logic zeros;
      ones  = 1'b1;
      zeros = 1'b1;
      for (int unsigned k = 0; k < n; k++) begin
         ones  = ones & v[k];
         zeros = zeros & ~v[k];
      end
      return ones | zeros;
   endfunction

endpackage

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter #(
   parameter int unsigned SAMPLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level
);
   import irq_hier_pkg::*;

   localparam int unsigned HIST_W = SAMPLES - 1;

   if (SAMPLES < 2 || SAMPLES > 16) begin : g_bad_samples
      $error("irq_glitch_filter: SAMPLES must be 2..16");
   end

   logic [HIST_W-1:0]  hist_q;
   logic [SAMPLES-1:0] window;
   logic [31:0]        window_ext;
   logic               level_q;

   assign window     = {hist_q, pin};
   assign window_ext = 32'(window);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q  <= '1;
         level_q <= 1'b1;
      end else begin
         hist_q <= window[HIST_W-1:0];
         if (all_same(window_ext, SAMPLES)) level_q <= pin;
      end
   end

   assign level = level_q;

   AST_FILT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q != $past(level_q)) |-> ($past(pin) == level_q && $past(pin, 2) == level_q)); // R2

endmodule

// File: rtl/irq_ext_path.sv
module irq_ext_path #(
   parameter int unsigned NUM_EXT  = 6,
   parameter int unsigned SAMPLES  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sys_en,
   input  logic               stop_mode,
   input  logic [NUM_EXT-1:0] pin_n,
   input  logic [NUM_EXT-1:0] local_en,
   input  logic [NUM_EXT-1:0] edge_sel,
   input  logic [NUM_EXT-1:0] clr,
   output logic [NUM_EXT-1:0] flag,
   output logic               wake_req
);
   import irq_hier_pkg::*;

   if (NUM_EXT < 1) begin : g_bad_ext
      $error("irq_ext_path: NUM_EXT must be at least 1");
   end

   logic [NUM_EXT-1:0] filt;
   logic [NUM_EXT-1:0] eff_level;
   logic [NUM_EXT-1:0] prev_q;
   logic [NUM_EXT-1:0] latch_q;

   for (genvar i = 0; i < NUM_EXT; i++) begin : g_ch
      trig_mode_e mode;
      logic       fall;

      irq_glitch_filter #(.SAMPLES(SAMPLES)) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (pin_n[i]),
         .level (filt[i])
      );

      assign eff_level[i] = stop_mode ? pin_n[i] : filt[i];
      assign mode         = trig_mode_e'(edge_sel[i]);
      assign fall         = prev_q[i] & ~eff_level[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[i]  <= 1'b1;
            latch_q[i] <= 1'b0;
         end else if (sys_en) begin
            prev_q[i] <= eff_level[i];
            if (mode == TRIG_EDGE && fall) latch_q[i] <= 1'b1;
            else if (clr[i])               latch_q[i] <= 1'b0;
         end
      end

      assign flag[i] = (mode == TRIG_EDGE) ? latch_q[i] : ~eff_level[i];

      AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_sel[i] && latch_q[i] && !(sys_en && clr[i])) |=> latch_q[i]); // R9
   end

   assign wake_req = stop_mode & (|(~pin_n & local_en));

   AST_WAKE_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> stop_mode); // R11

endmodule

// File: rtl/irq_enable_tree.sv
module irq_enable_tree #(
   parameter int unsigned NUM_GRP = 3,
   parameter int unsigned GRP_W   = 4,
   parameter int unsigned NUM_EXT = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_GRP*GRP_W-1:0]   int_flag,
   input  logic [NUM_GRP*GRP_W-1:0]   int_local_en,
   input  logic [NUM_EXT-1:0]         ext_flag,
   input  logic [NUM_EXT-1:0]         ext_local_en,
   input  logic [NUM_GRP:0]           grp_en,
   input  logic                       sys_ie,
   input  logic                       glob_ie,
   output logic [NUM_GRP:0]           grp_pend,
   output logic                       raw_req
);
   if (NUM_GRP < 1 || GRP_W < 1) begin : g_bad_grp
      $error("irq_enable_tree: NUM_GRP and GRP_W must be at least 1");
   end

   logic [NUM_GRP*GRP_W-1:0] int_armed;
   logic [NUM_EXT-1:0]       ext_armed;

   assign int_armed = int_flag & int_local_en;
   assign ext_armed = ext_flag & ext_local_en;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      assign grp_pend[g] = grp_en[g] & (|int_armed[g*GRP_W +: GRP_W]);

      AST_GRP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         grp_pend[g] |-> (grp_en[g] && |(int_flag[g*GRP_W +: GRP_W] & int_local_en[g*GRP_W +: GRP_W]))); // R5
   end

   assign grp_pend[NUM_GRP] = grp_en[NUM_GRP] & (|ext_armed);
   assign raw_req           = glob_ie & sys_ie & (|grp_pend);

   AST_TOP_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      raw_req |-> (sys_ie && glob_ie && grp_pend != '0)); // R6

endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl #(
   parameter int unsigned NUM_GRP = 3,
   parameter int unsigned GRP_W   = 4,
   parameter int unsigned NUM_EXT = 6,
   parameter int unsigned SAMPLES = 3
) (
   input  logic                     clk_src,
   input  logic                     rst_n,
   input  logic                     sys_en,
   input  logic                     stop_mode,
   input  logic [NUM_GRP*GRP_W-1:0] int_flag,
   input  logic [NUM_GRP*GRP_W-1:0] int_local_en,
   input  logic [NUM_EXT-1:0]       ext_pin_n,
   input  logic [NUM_EXT-1:0]       ext_local_en,
   input  logic [NUM_EXT-1:0]       ext_edge_sel,
   input  logic [NUM_EXT-1:0]       ext_clr,
   input  logic [NUM_GRP:0]         grp_en,
   input  logic                     sys_ie,
   input  logic                     glob_ie,
   input  logic                     irq_ack,
   input  logic                     irq_reti,
   output logic                     irq_req,
   output logic                     in_service,
   output logic [NUM_EXT-1:0]       ext_flag,
   output logic [NUM_GRP:0]         grp_pend,
   output logic                     wake_req
);
   logic raw_req;
   logic isv_q;

   irq_ext_path #(.NUM_EXT(NUM_EXT), .SAMPLES(SAMPLES)) u_ext (
      .clk       (clk_src),
      .rst_n     (rst_n),
      .sys_en    (sys_en),
      .stop_mode (stop_mode),
      .pin_n     (ext_pin_n),
      .local_en  (ext_local_en),
      .edge_sel  (ext_edge_sel),
      .clr       (ext_clr),
      .flag      (ext_flag),
      .wake_req  (wake_req)
   );

   irq_enable_tree #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .NUM_EXT(NUM_EXT)) u_tree (
      .clk          (clk_src),
      .rst_n        (rst_n),
      .int_flag     (int_flag),
      .int_local_en (int_local_en),
      .ext_flag     (ext_flag),
      .ext_local_en (ext_local_en),
      .grp_en       (grp_en),
      .sys_ie       (sys_ie),
      .glob_ie      (glob_ie),
      .grp_pend     (grp_pend),
      .raw_req      (raw_req)
   );

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n)        isv_q <= 1'b0;
      else if (sys_en) begin
         if (irq_ack)       isv_q <= 1'b1;
         else if (irq_reti) isv_q <= 1'b0;
      end
   end

   assign in_service = isv_q;
   assign irq_req    = raw_req & ~isv_q;

   AST_NO_REQ_IN_SERVICE: assert property (@(posedge clk_src) disable iff (!rst_n)
      in_service |-> !irq_req); // R8
   AST_ACK_SETS: assert property (@(posedge clk_src) disable iff (!rst_n)
      (sys_en && irq_ack) |=> in_service); // R8
   AST_RETI_CLEARS: assert property (@(posedge clk_src) disable iff (!rst_n)
      (sys_en && irq_reti && !irq_ack) |=> !in_service); // R8
   AST_ISV_STROBED: assert property (@(posedge clk_src) disable iff (!rst_n)
      !sys_en |=> $stable(in_service)); // R8

endmodule

// File: tb/sim_irq_hier_ctrl.sv
module sim_irq_hier_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk_src = 1'b0;
   logic        rst_n = 1'b0;
   logic        sys_en = 1'b1;
   logic        stop_mode = 1'b0;
   logic [11:0] int_flag = '0;
   logic [11:0] int_local_en = '0;
   logic [5:0]  ext_pin_n = '1;
   logic [5:0]  ext_local_en = '0;
   logic [5:0]  ext_edge_sel = '0;
   logic [5:0]  ext_clr = '0;
   logic [3:0]  grp_en = '0;
   logic        sys_ie = 1'b0;
   logic        glob_ie = 1'b0;
   logic        irq_ack = 1'b0;
   logic        irq_reti = 1'b0;
   logic        irq_req;
   logic        in_service;
   logic [5:0]  ext_flag;
   logic [3:0]  grp_pend;
   logic        wake_req;

   int checks = 0;
   int errors = 0;
   int div_ratio = 1;
   int div_cnt = 0;
   bit done = 1'b0;

   irq_hier_ctrl u0 (
      .clk_src(clk_src), .rst_n(rst_n), .sys_en(sys_en), .stop_mode(stop_mode),
      .int_flag(int_flag), .int_local_en(int_local_en), .ext_pin_n(ext_pin_n),
      .ext_local_en(ext_local_en), .ext_edge_sel(ext_edge_sel), .ext_clr(ext_clr),
      .grp_en(grp_en), .sys_ie(sys_ie), .glob_ie(glob_ie), .irq_ack(irq_ack),
      .irq_reti(irq_reti), .irq_req(irq_req), .in_service(in_service),
      .ext_flag(ext_flag), .grp_pend(grp_pend), .wake_req(wake_req)
   );

   always #(CLK_PERIOD/2) clk_src = ~clk_src;

   always @(negedge clk_src) begin
      div_cnt = (div_cnt + 1) % div_ratio;
      sys_en  = (div_cnt == 0);
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(int n);
      for (int k = 0; k < n; k++) @(posedge clk_src);
      #1;
   endtask

   task automatic all_on();
      grp_en  = '1;
      sys_ie  = 1'b1;
      glob_ie = 1'b1;
   endtask

   task automatic t_reset();
      #1;
      chk("R12 irq_req", irq_req, 0);
      chk("R12 in_service", in_service, 0);
      chk("R12 ext_flag", ext_flag, 0);
      chk("R12 grp_pend", grp_pend, 0);
      chk("R12 wake_req", wake_req, 0);
   endtask

   task automatic t_internal();
      @(negedge clk_src);
      all_on();
      int_local_en = 12'h020;
      int_flag     = 12'h020;
      #1;
      chk("R1 irq_req same cycle", irq_req, 1);
      chk("R5 grp_pend group1", grp_pend, 4'b0010);
      int_flag = '0;
      #1;
      chk("R1 irq_req drops", irq_req, 0);
   endtask

   task automatic t_gates();
      @(negedge clk_src);
      int_flag = 12'h004; int_local_en = 12'h000; #1;
      chk("R4 local enable off", {grp_pend, irq_req}, 5'b0);
      int_local_en = 12'h004; grp_en = 4'b1110; #1;
      chk("R5 group enable off", {grp_pend, irq_req}, 5'b0);
      grp_en = '1; sys_ie = 1'b0; #1;
      chk("R6 system enable off", {grp_pend, irq_req}, 5'b00010);
      sys_ie = 1'b1; glob_ie = 1'b0; #1;
      chk("R7 global enable off", {grp_pend, irq_req}, 5'b00010);
      glob_ie = 1'b1; #1;
      chk("R7 all enables on", irq_req, 1);
   endtask

   task automatic t_service();
      @(negedge clk_src); irq_ack = 1'b1;
      @(negedge clk_src); irq_ack = 1'b0; #1;
      chk("R8 in_service set", in_service, 1);
      chk("R8 request blocked", irq_req, 0);
      step(2);
      chk("R8 still blocked", irq_req, 0);
      @(negedge clk_src); irq_reti = 1'b1;
      @(negedge clk_src); irq_reti = 1'b0; #1;
      chk("R8 in_service cleared", in_service, 0);
      chk("R8 request back", irq_req, 1);
      int_flag = '0; int_local_en = '0;
   endtask

   task automatic t_filter();
      @(negedge clk_src);
      ext_local_en = 6'h01;
      ext_pin_n[0] = 1'b0;
      @(negedge clk_src);
      @(negedge clk_src); ext_pin_n[0] = 1'b1;
      begin
         logic seen = 1'b0;
         for (int k = 0; k < 6; k++) begin
            step(1);
            seen = seen | ext_flag[0];
         end
         chk("R2 2-cycle glitch rejected", seen, 0);
      end
      @(negedge clk_src); ext_pin_n[0] = 1'b0;
      step(2);
      chk("R2 not yet after 2 samples", ext_flag[0], 0);
      step(1);
      chk("R10 level flag after 3 samples", ext_flag[0], 1);
      chk("R2 irq_req from pin", irq_req, 1);
      @(negedge clk_src); ext_pin_n[0] = 1'b1;
      step(2);
      chk("R10 level still held", ext_flag[0], 1);
      step(1);
      chk("R10 level flag follows release", ext_flag[0], 0);
      ext_local_en = '0;
   endtask

   task automatic t_edge();
      @(negedge clk_src);
      ext_edge_sel = 6'h02; ext_local_en = 6'h02;
      ext_pin_n[1] = 1'b0;
      step(3);
      chk("R9 edge flag not before strobe", ext_flag[1], 0);
      step(1);
      chk("R9 edge flag set", ext_flag[1], 1);
      @(negedge clk_src); ext_pin_n[1] = 1'b1;
      step(6);
      chk("R9 edge flag kept after release", ext_flag[1], 1);
      @(negedge clk_src); ext_clr[1] = 1'b1;
      @(negedge clk_src); ext_clr[1] = 1'b0; #1;
      chk("R9 edge flag cleared", ext_flag[1], 0);
      ext_edge_sel = '0; ext_local_en = '0;
   endtask

   task automatic t_divided();
      int strobes = 0;
      ext_local_en = 6'h04;
      div_ratio = 3;
      do @(posedge clk_src); while (!sys_en);
      @(negedge clk_src); ext_pin_n[2] = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk_src);
         if (sys_en) strobes++;
         #1;
         if (k == 1) chk("R3 not recognized after 2 source cycles", irq_req, 0);
      end
      chk("R3 recognized after 3 source cycles", irq_req, 1);
      chk("R3 one system strobe elapsed", strobes, 1);
      do @(posedge clk_src); while (!sys_en);
      @(negedge clk_src); irq_ack = 1'b1;
      @(negedge clk_src); irq_ack = 1'b0; #1;
      chk("R8 ack off strobe ignored", in_service, 0);
      ext_pin_n[2] = 1'b1;
      div_ratio = 1;
      step(5);
      ext_local_en = '0;
   endtask

   task automatic t_stop();
      @(negedge clk_src);
      stop_mode = 1'b1; ext_local_en = 6'h08;
      ext_pin_n[3] = 1'b0; #1;
      chk("R11 wake combinational", wake_req, 1);
      chk("R11 flag bypasses filter", ext_flag[3], 1);
      ext_local_en = 6'h00; #1;
      chk("R11 wake needs local enable", wake_req, 0);
      ext_local_en = 6'h08; stop_mode = 1'b0; #1;
      chk("R11 no wake outside stop", wake_req, 0);
      ext_pin_n[3] = 1'b1; ext_local_en = '0;
      step(5);
   endtask

   initial begin
      repeat (3) @(posedge clk_src);
      @(negedge clk_src); rst_n = 1'b1;
      t_reset();
      t_internal();
      t_gates();
      t_service();
      t_filter();
      t_edge();
      t_divided();
      t_stop();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule